// File: doc/BRIEF.md
# Self-checking duplicated forwarding-select logic

This block computes an operand forwarding select for one pipeline stage and guards it against transient upsets. Two identical copies of the select logic see the same operands. Each cycle the block compares their outputs. When they agree, the result may be written into the stage's pipeline register, provided the upstream load enable is high. When they disagree, the block holds the stage in the same cycle. The register keeps its contents, and the same operands are evaluated again on the next cycle. Nothing is flushed and no in-flight work is dropped. The hold ends in the first cycle in which the copies agree again.

A counter records how many disagreeing cycles have come one after another. If that run reaches a limit set by a parameter, a sticky fatal flag is raised, because the fault is evidently not transient. A mask input inverts selected bits of the shadow copy's output. It exists so that upsets can be injected for test and is tied to zero in normal use.

Top module: `ctl_dup_checker`

## Requirements
- R1: Each copy produces a 2-bit select: 2'b01 when the near stage writes the source register, otherwise 2'b10 when the far stage writes it, otherwise 2'b00. Register index 0 is never forwarded, and the near stage wins when both stages match.
- R2: The copies are compared every cycle. `mismatch` and `hold` are high in the same cycle in which the two outputs differ, before any clock edge, whether or not `load_en_in` is high.
- R3: `stage_ld` equals `load_en_in` while the copies agree and is low on a disagreement. At a rising edge with `stage_ld` high, `sel_out` takes the agreed select value.
- R4: While `hold` is high, `sel_out` keeps the last value loaded while the copies agreed.
- R5: An N-cycle disagreement holds the stage for exactly N cycles. The stage then loads the value for the still-present operands in the first agreeing cycle.
- R6: `retry_cnt` counts consecutive disagreeing cycles, saturates at FATAL_LIMIT, and returns to 0 after any agreeing cycle.
- R7: `fatal` goes high at the edge on which the run of disagreeing cycles reaches FATAL_LIMIT. After that it stays high until reset.
- R8: A synchronous active-low reset clears `sel_out` to 2'b00, `retry_cnt` to 0 and `fatal` to 0.
- R9: With `load_en_in` low and the copies agreeing, `hold` is low and `sel_out` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en_in | input | 1 | Upstream load enable of the stage register |
| src_reg | input | REG_W | Source register index of the consuming instruction |
| near_dst | input | REG_W | Destination index of the nearer in-flight result |
| near_wr | input | 1 | Nearer result writes a register |
| far_dst | input | REG_W | Destination index of the farther in-flight result |
| far_wr | input | 1 | Farther result writes a register |
| inj_mask | input | 2 | Bits inverted on the shadow copy's output (test only) |
| sel_out | output | 2 | Registered agreed forwarding select |
| stage_ld | output | 1 | Gated load enable of the stage register |
| hold | output | 1 | Stage hold, high while the copies disagree |
| mismatch | output | 1 | Error flag for the current cycle |
| retry_cnt | output | CNT_W | Consecutive disagreeing cycles, saturating |
| fatal | output | 1 | Sticky flag: disagreement run reached the limit |

## Verification
The bench builds the block with REG_W = 3 and FATAL_LIMIT = 6. A 3-bit index lets every combination of source index, both destination indices and both write flags be swept through the forwarding logic. That covers index zero and all priority overlaps. The small limit puts the saturation of the retry counter and the raising of the sticky fatal flag within a few cycles, right after exact-length hold runs of one to five cycles with every injection mask.

// File: rtl/dupctl_pkg.sv
// Package: shared widths and the forwarding-select encoding.
// Assumes a two-source forwarding network (near and far in-flight stages).
package dupctl_pkg;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        FWD_NONE = 2'b00,
        FWD_NEAR = 2'b01,
        FWD_FAR  = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/fwd_select_copy.sv
// One copy of the dynamic forwarding-select logic.
// Assumes register index 0 is hard-wired and never needs forwarding.
module fwd_select_copy
    import dupctl_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src_reg,
    input  logic [REG_W-1:0] near_dst,
    input  logic             near_wr,
    input  logic [REG_W-1:0] far_dst,
    input  logic             far_wr,
    output logic [SEL_W-1:0] sel
);
    logic src_live;
    assign src_live = (src_reg != '0);

    // Priority pick: the nearer producer overrides the farther one.
    always_comb begin
        sel = FWD_NONE;
        if (src_live && far_wr && (far_dst == src_reg))
            sel = FWD_FAR;
        if (src_live && near_wr && (near_dst == src_reg))
            sel = FWD_NEAR;
    end
endmodule

// File: rtl/dup_compare.sv
// Compares the primary and shadow outputs every cycle and gates the load.
// Assumes both inputs are settled within the cycle (purely combinational).
module dup_compare #(
    parameter int W = 2
) (
    input  logic [W-1:0] val_p,
    input  logic [W-1:0] val_s,
    input  logic         load_en,
    output logic         mismatch,
    output logic         stage_ld
);
    // Disagreement detection and load gating, same cycle.
    always_comb begin
        mismatch = (val_p != val_s);
        stage_ld = load_en && !mismatch;
    end
endmodule

// File: rtl/retry_tracker.sv
// Counts consecutive disagreeing cycles and raises a sticky fatal flag.
// Assumes FATAL_LIMIT >= 1; the counter saturates at FATAL_LIMIT.
module retry_tracker #(
    parameter int FATAL_LIMIT = 16,
    localparam int CNT_W = $clog2(FATAL_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mismatch,
    output logic [CNT_W-1:0] cnt_q,
    output logic             fatal_q
);
    localparam logic [CNT_W-1:0] LIM   = CNT_W'(FATAL_LIMIT);
    localparam logic [CNT_W-1:0] LIM_M = CNT_W'(FATAL_LIMIT - 1);

    // Run-length counter of disagreeing cycles, cleared by any agreement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!mismatch)
            cnt_q <= '0;
        else if (cnt_q != LIM)
            cnt_q <= cnt_q + 1'b1;
    end

    // Sticky fatal flag, set when the run reaches the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fatal_q <= 1'b0;
        else if (mismatch && (cnt_q >= LIM_M))
            fatal_q <= 1'b1;
    end

    // R6
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mismatch |=> (cnt_q == '0));

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM);

    // R7
    fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_q |=> fatal_q);

    // R7
    fatal_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == LIM) |-> fatal_q);
endmodule

// File: rtl/ctl_dup_checker.sv
// Top: two copies of the forwarding select, a comparator, the stage
// register and the retry tracker. On disagreement the stage is held and
// re-evaluated in place; nothing is flushed.
// Assumes inj_mask is tied to zero outside of test.
module ctl_dup_checker
    import dupctl_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int FATAL_LIMIT = 16,
    localparam int CNT_W = $clog2(FATAL_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en_in,
    input  logic [REG_W-1:0] src_reg,
    input  logic [REG_W-1:0] near_dst,
    input  logic             near_wr,
    input  logic [REG_W-1:0] far_dst,
    input  logic             far_wr,
    input  logic [1:0]       inj_mask,
    output logic [1:0]       sel_out,
    output logic             stage_ld,
    output logic             hold,
    output logic             mismatch,
    output logic [CNT_W-1:0] retry_cnt,
    output logic             fatal
);
    localparam int N_COPY = 2;

    logic [SEL_W-1:0] copy_sel [N_COPY];
    logic [SEL_W-1:0] primary_sel;
    logic [SEL_W-1:0] shadow_sel;
    logic [SEL_W-1:0] sel_q;
    logic             miss;
    logic             ld;

    // Identical replicas of the control function.
    for (genvar g = 0; g < N_COPY; g++) begin : g_copy
        fwd_select_copy #(.REG_W(REG_W)) copy_i (
            .src_reg  (src_reg),
            .near_dst (near_dst),
            .near_wr  (near_wr),
            .far_dst  (far_dst),
            .far_wr   (far_wr),
            .sel      (copy_sel[g])
        );
    end

    assign primary_sel = copy_sel[0];
    assign shadow_sel  = copy_sel[1] ^ inj_mask;

    dup_compare #(.W(SEL_W)) cmp_i (
        .val_p    (primary_sel),
        .val_s    (shadow_sel),
        .load_en  (load_en_in),
        .mismatch (miss),
        .stage_ld (ld)
    );

    // Stage register: loads only agreed values.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= FWD_NONE;
        else if (ld)
            sel_q <= primary_sel;
    end

    retry_tracker #(.FATAL_LIMIT(FATAL_LIMIT)) trk_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mismatch (miss),
        .cnt_q    (retry_cnt),
        .fatal_q  (fatal)
    );

    assign sel_out  = sel_q;
    assign stage_ld = ld;
    assign hold     = miss;
    assign mismatch = miss;

    // R4
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> $stable(sel_q));

    // R3
    load_agreed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (sel_q == $past(primary_sel)));

    // R9
    idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en_in |=> $stable(sel_q));
endmodule

// File: tb/ctl_dup_checker_tb_top.sv
// Bench: exhaustive sweep of the forwarding select at REG_W=3, then
// exact-length hold runs, saturation and sticky fatal at FATAL_LIMIT=6.
// Clock: 4 time units per period (250 MHz at 1 ns units).
module ctl_dup_checker_tb_top;
    localparam int RW  = 3;
    localparam int LIM = 6;
    localparam int CW  = $clog2(LIM + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_en_in = 1'b0;
    logic [RW-1:0] src_reg = '0, near_dst = '0, far_dst = '0;
    logic          near_wr = 1'b0, far_wr = 1'b0;
    logic [1:0]    inj_mask = '0;
    logic [1:0]    sel_out;
    logic          stage_ld, hold, mismatch, fatal;
    logic [CW-1:0] retry_cnt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ctl_dup_checker #(.REG_W(RW), .FATAL_LIMIT(LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_en_in(load_en_in),
        .src_reg(src_reg), .near_dst(near_dst), .near_wr(near_wr),
        .far_dst(far_dst), .far_wr(far_wr), .inj_mask(inj_mask),
        .sel_out(sel_out), .stage_ld(stage_ld), .hold(hold),
        .mismatch(mismatch), .retry_cnt(retry_cnt), .fatal(fatal)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic int exp_sel(int s, int nd, int nw, int fd, int fw);
        if (s != 0 && nw != 0 && nd == s) return 1;
        if (s != 0 && fw != 0 && fd == s) return 2;
        return 0;
    endfunction

    // Drive at the falling edge, then settle one unit for comb checks.
    task automatic drive(input int s, input int nd, input int nw, input int fd,
                         input int fw, input int le, input int msk);
        @(negedge clk);
        src_reg = RW'(s); near_dst = RW'(nd); near_wr = nw[0];
        far_dst = RW'(fd); far_wr = fw[0];
        load_en_in = le[0]; inj_mask = 2'(msk);
        #1;
    endtask

    // Wait for the rising edge and sample registered outputs after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #600000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        int v0, v1, held;
        // R8 reset state
        rst_n = 1'b0;
        drive(3, 3, 1, 0, 0, 1, 0);
        tick(); tick();
        check("R8 sel_out", sel_out, 0);
        check("R8 retry_cnt", retry_cnt, 0);
        check("R8 fatal", fatal, 0);
        rst_n = 1'b1;

        // R1/R3: exhaustive sweep with loading enabled
        for (int s = 0; s < 8; s++)
            for (int nd = 0; nd < 8; nd++)
                for (int fd = 0; fd < 8; fd++)
                    for (int w = 0; w < 4; w++) begin
                        drive(s, nd, w & 1, fd, w >> 1, 1, 0);
                        check("R3 stage_ld", stage_ld, 1);
                        tick();
                        check("R1 sel_out", sel_out, exp_sel(s, nd, w & 1, fd, w >> 1));
                    end

        // R5/R4/R2/R6: exact-length hold runs
        v0 = 1; v1 = 2;
        for (int n = 1; n <= 5; n++) begin
            drive(5, 5, 1, 0, 0, 1, 0);
            tick();
            check("R3 preload", sel_out, v0);
            held = 0;
            for (int k = 1; k <= n; k++) begin
                drive(5, 0, 0, 5, 1, 1, (n + k) % 3 + 1);
                check("R2 hold", hold, 1);
                check("R2 mismatch", mismatch, 1);
                check("R3 stage_ld gated", stage_ld, 0);
                if (hold) held++;
                tick();
                check("R4 sel_out kept", sel_out, v0);
                check("R6 retry_cnt", retry_cnt, k);
            end
            drive(5, 0, 0, 5, 1, 1, 0);
            check("R5 hold released", hold, 0);
            check("R5 stage_ld", stage_ld, 1);
            check("R6 run length", retry_cnt, n);
            check("R5 held cycles", held, n);
            tick();
            check("R5 reload", sel_out, v1);
            check("R6 retry cleared", retry_cnt, 0);
        end

        // R9: load enable low, copies agree
        drive(4, 4, 1, 0, 0, 0, 0);
        check("R9 hold", hold, 0);
        check("R9 stage_ld", stage_ld, 0);
        tick();
        check("R9 sel_out", sel_out, v1);

        // R2: disagreement flagged with load enable low
        drive(4, 4, 1, 0, 0, 0, 3);
        check("R2 hold idle", hold, 1);
        tick();
        check("R6 count idle", retry_cnt, 1);

        // R6/R7: saturation and sticky fatal
        for (int k = 2; k <= 9; k++) begin
            drive(4, 4, 1, 0, 0, 1, 2);
            tick();
            check("R6 saturate", retry_cnt, (k < LIM) ? k : LIM);
            check("R7 fatal", fatal, (k >= LIM) ? 1 : 0);
            check("R4 held", sel_out, v1);
        end
        drive(4, 4, 1, 0, 0, 1, 0);
        tick();
        check("R7 sticky", fatal, 1);
        check("R6 cleared", retry_cnt, 0);
        check("R3 load after", sel_out, 1);

        // R8: reset clears the sticky flag
        rst_n = 1'b0;
        tick();
        check("R8 fatal reset", fatal, 0);
        check("R8 sel reset", sel_out, 0);
        rst_n = 1'b1;
        tick();
        finish_run();
    end
endmodule